// File: doc/BRIEF.md
# Output voltage fault supervisor

This block supervises a regulator output by comparing a digitized feedback sample against a reference code. It detects undervoltage and overvoltage using programmable percentage thresholds with a fixed hysteresis band. It drives a power-good output and sets sticky fault flags. It raises an active-low alert while any flag is set. When a fault is not masked, it asks the power stage to stop switching.

A mask register decides whether each fault stops switching. A masked fault is still flagged, and it still pulls power-good low. A response register selects what happens after an unmasked fault. In hiccup mode, switching resumes with a one-cycle soft-start restart request once every unmasked condition has recovered. In latch-off mode, switching stays stopped until reset. A small read/write register port gives access to the flags, the mask, the response mode and the threshold codes. A separate strobe clears every flag.

Power-good uses three states: `PG_LOW`, `PG_WAIT` and `PG_HIGH`.
- `PG_LOW` to `PG_WAIT`: no fault condition is present and soft-start is idle.
- `PG_WAIT` to `PG_HIGH`: `PG_DELAY_CYC` cycles have elapsed.
- Any state to `PG_LOW`: a fault condition appears. `PG_WAIT` also returns to `PG_LOW` when soft-start becomes active.

Protection uses four states: `PR_RUN`, `PR_HICCUP_OFF`, `PR_RESTART` and `PR_LATCHED`.
- `PR_RUN` to `PR_HICCUP_OFF`: an unmasked fault appears and hiccup mode is selected.
- `PR_RUN` to `PR_LATCHED`: an unmasked fault appears and latch-off mode is selected.
- `PR_HICCUP_OFF` to `PR_RESTART`: no unmasked condition remains.
- `PR_RESTART` to `PR_RUN`: always, after one cycle.
- `PR_LATCHED` is left only through reset.

Top module: `vout_fault_supervisor`

## Requirements
- R1: The undervoltage condition trips when fb*100 < ref*(70 + 2*U), where U is bits [2:0] of the limits register at address 3 (reset U=5, so 80%). It appears one cycle after the sample. It is forced inactive while `ss_active` is 1.
- R2: The overvoltage condition trips when fb*100 > ref*(110 + 2*V), where V is bits [5:3] of the limits register (reset V=5, so 120%). It stays active during soft-start.
- R3: An active undervoltage condition clears only when fb*100 > ref*(pct+4). An active overvoltage condition clears only when fb*100 < ref*(pct-4). Inside the band, the condition holds.
- R4: `pg` falls in the cycle after a fault condition appears. After every condition has cleared and `ss_active` is 0, `pg` rises only after `PG_DELAY_CYC` cycles.
- R5: Status register (address 0): bit 7 is overvoltage and bit 6 is undervoltage, and all other bits read 0. A bit is set in every cycle that its condition is active. Otherwise it holds its value.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A `clear_faults` pulse clears both bits. An active condition sets its bit again.
- R7: `alert_n` is 0 while any status bit is 1, and 1 when both bits are 0.
- R8: Mask register (address 1): bit 7 masks overvoltage and bit 6 masks undervoltage, and it resets to 0x40. A masked fault sets its flag and lowers `pg`, but `pwm_off` stays 0.
- R9: An unmasked fault sets `pwm_off` two cycles after the sample that causes it.
- R10: With response bit 0 (address 2) at 0 (hiccup, the reset value), `pwm_off` returns to 0 once every unmasked condition has cleared. `restart_req` pulses for exactly one cycle as that happens.
- R11: With response bit 0 at 1 (latch-off), `pwm_off` stays 1 after recovery and no restart is requested. Only reset clears it.
- R12: `reg_rdata` reads combinationally at `reg_addr`. The reset values are status 0x00, mask 0x40, response 0x00 and limits 0x2D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_sample | input | SAMPLE_W | Digitized feedback sample |
| ref_code | input | SAMPLE_W | Regulation reference code |
| ss_active | input | 1 | Soft-start ramp in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| clear_faults | input | 1 | Clears all status bits |
| pg | output | 1 | Power good |
| alert_n | output | 1 | Active-low alert |
| pwm_off | output | 1 | Request to stop switching |
| restart_req | output | 1 | One-cycle soft-start restart request |

## Verification
A wrong condition register shows up within two cycles as a wrong status bit and a wrong `alert_n`. If the hysteresis state is stuck, flags appear or vanish for samples inside the band. A miscounted power-good timer moves the `pg` rising edge away from the programmed delay, and it is caught on the first recovery. A protection state machine in the wrong state shows within one cycle of a trip or recovery: `pwm_off` takes the wrong value, or `restart_req` is missing or doubled.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [1:0] {
        PG_LOW,
        PG_WAIT,
        PG_HIGH
    } pg_state_e;

    typedef enum logic [1:0] {
        PR_RUN,
        PR_HICCUP_OFF,
        PR_RESTART,
        PR_LATCHED
    } prot_state_e;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_MASK   = 2'd1;
    localparam logic [1:0] ADDR_RESP   = 2'd2;
    localparam logic [1:0] ADDR_LIMITS = 2'd3;

    localparam int BIT_OV = 7;
    localparam int BIT_UV = 6;

    localparam logic [1:0] MASK_RESET   = 2'b01;
    localparam logic [2:0] UV_CODE_RST  = 3'd5;
    localparam logic [2:0] OV_CODE_RST  = 3'd5;

    localparam int UV_BASE_PCT = 70;
    localparam int OV_BASE_PCT = 110;
    localparam int PCT_STEP    = 2;
    localparam int HYST_PCT    = 4;

    function automatic logic [6:0] uv_pct(input logic [2:0] code);
        return 7'(UV_BASE_PCT + PCT_STEP * int'(code));
    endfunction

    function automatic logic [6:0] ov_pct(input logic [2:0] code);
        return 7'(OV_BASE_PCT + PCT_STEP * int'(code));
    endfunction

endpackage

// File: rtl/vfs_window_cmp.sv
module vfs_window_cmp #(
    parameter int SAMPLE_W = 12,
    parameter bit OVER     = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] fb,
    input  logic [SAMPLE_W-1:0] refv,
    input  logic [6:0]          pct,
    output logic                cond
);
    import vfs_pkg::*;

    localparam int PW = SAMPLE_W + 7;

    logic [PW-1:0] fb_x;
    logic [PW-1:0] trip_x;
    logic [PW-1:0] rel_x;
    logic [6:0]    rel_pct;
    logic          trip;
    logic          release_ok;
    logic          cond_d;

    generate
        if (OVER) begin : g_over
            assign rel_pct    = pct - 7'(HYST_PCT);
            assign trip       = fb_x > trip_x;
            assign release_ok = fb_x < rel_x;
        end else begin : g_under
            assign rel_pct    = pct + 7'(HYST_PCT);
            assign trip       = fb_x < trip_x;
            assign release_ok = fb_x > rel_x;
        end
    endgenerate

    always_comb begin
        fb_x   = PW'(fb) * PW'(100);
        trip_x = PW'(refv) * PW'(pct);
        rel_x  = PW'(refv) * PW'(rel_pct);
        if (!en) begin
            cond_d = 1'b0;
        end else if (cond) begin
            cond_d = !release_ok;
        end else begin
            cond_d = trip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond <= 1'b0;
        end else begin
            cond <= cond_d;
        end
    end

endmodule

// File: rtl/vfs_pg_timer.sv
module vfs_pg_timer #(
    parameter int DELAY_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic ss_active,
    output logic pg
);
    import vfs_pkg::*;

    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    pg_state_e     state_q;
    pg_state_e     state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_LOW: begin
                if (!fault && !ss_active) state_d = PG_WAIT;
            end
            PG_WAIT: begin
                if (fault || ss_active) state_d = PG_LOW;
                else if (cnt_q == LAST) state_d = PG_HIGH;
            end
            PG_HIGH: begin
                if (fault) state_d = PG_LOW;
            end
            default: state_d = PG_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == PG_WAIT) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        pg = (state_q == PG_HIGH) && !fault;
    end

endmodule

// File: rtl/vfs_regs.sv
module vfs_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       clear_faults,
    input  logic       uv_cond,
    input  logic       ov_cond,
    output logic [7:0] reg_rdata,
    output logic [1:0] status_q,
    output logic [1:0] mask_q,
    output logic       latch_mode,
    output logic [2:0] uv_code,
    output logic [2:0] ov_code
);
    import vfs_pkg::*;

    logic [1:0] clr_bits;
    logic [1:0] set_bits;

    always_comb begin
        clr_bits = '0;
        if (clear_faults) begin
            clr_bits = 2'b11;
        end else if (reg_wr && reg_addr == ADDR_STATUS) begin
            clr_bits = {reg_wdata[BIT_OV], reg_wdata[BIT_UV]};
        end
        set_bits = {ov_cond, uv_cond};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q   <= '0;
            mask_q     <= MASK_RESET;
            latch_mode <= 1'b0;
            uv_code    <= UV_CODE_RST;
            ov_code    <= OV_CODE_RST;
        end else begin
            status_q <= (status_q & ~clr_bits) | set_bits;
            if (reg_wr) begin
                unique case (reg_addr)
                    ADDR_MASK:   mask_q     <= {reg_wdata[BIT_OV], reg_wdata[BIT_UV]};
                    ADDR_RESP:   latch_mode <= reg_wdata[0];
                    ADDR_LIMITS: begin
                        uv_code <= reg_wdata[2:0];
                        ov_code <= reg_wdata[5:3];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: begin
                reg_rdata[BIT_OV] = status_q[1];
                reg_rdata[BIT_UV] = status_q[0];
            end
            ADDR_MASK: begin
                reg_rdata[BIT_OV] = mask_q[1];
                reg_rdata[BIT_UV] = mask_q[0];
            end
            ADDR_RESP:   reg_rdata[0]   = latch_mode;
            ADDR_LIMITS: reg_rdata[5:0] = {ov_code, uv_code};
            default:     reg_rdata      = '0;
        endcase
    end

endmodule

// File: rtl/vfs_prot_fsm.sv
module vfs_prot_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_cond,
    input  logic       ov_cond,
    input  logic [1:0] mask_q,
    input  logic       latch_mode,
    output logic       pwm_off,
    output logic       restart_req
);
    import vfs_pkg::*;

    prot_state_e state_q;
    prot_state_e state_d;
    logic        armed_fault;

    always_comb begin
        armed_fault = (ov_cond && !mask_q[1]) || (uv_cond && !mask_q[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_RUN: begin
                if (armed_fault) state_d = latch_mode ? PR_LATCHED : PR_HICCUP_OFF;
            end
            PR_HICCUP_OFF: begin
                if (!armed_fault) state_d = PR_RESTART;
            end
            PR_RESTART: state_d = PR_RUN;
            PR_LATCHED: state_d = PR_LATCHED;
            default:    state_d = PR_RUN;
        endcase
    end

    always_comb begin
        pwm_off     = 1'b0;
        restart_req = 1'b0;
        unique case (state_q)
            PR_RUN:        ;
            PR_HICCUP_OFF: pwm_off = 1'b1;
            PR_RESTART:    restart_req = 1'b1;
            PR_LATCHED:    pwm_off = 1'b1;
            default:       pwm_off = 1'b1;
        endcase
    end

endmodule

// File: rtl/vout_fault_supervisor.sv
module vout_fault_supervisor #(
    parameter int SAMPLE_W     = 12,
    parameter int PG_DELAY_CYC = 62500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] fb_sample,
    input  logic [SAMPLE_W-1:0] ref_code,
    input  logic                ss_active,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                clear_faults,
    output logic                pg,
    output logic                alert_n,
    output logic                pwm_off,
    output logic                restart_req
);
    import vfs_pkg::*;

    logic       uv_cond;
    logic       ov_cond;
    logic [1:0] status_q;
    logic [1:0] mask_q;
    logic       latch_mode;
    logic [2:0] uv_code;
    logic [2:0] ov_code;

    vfs_window_cmp #(.SAMPLE_W(SAMPLE_W), .OVER(1'b0)) uv_cmp_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (!ss_active),
        .fb   (fb_sample),
        .refv (ref_code),
        .pct  (uv_pct(uv_code)),
        .cond (uv_cond)
    );

    vfs_window_cmp #(.SAMPLE_W(SAMPLE_W), .OVER(1'b1)) ov_cmp_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (1'b1),
        .fb   (fb_sample),
        .refv (ref_code),
        .pct  (ov_pct(ov_code)),
        .cond (ov_cond)
    );

    vfs_pg_timer #(.DELAY_CYC(PG_DELAY_CYC)) pg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (uv_cond || ov_cond),
        .ss_active(ss_active),
        .pg       (pg)
    );

    vfs_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .clear_faults(clear_faults),
        .uv_cond     (uv_cond),
        .ov_cond     (ov_cond),
        .reg_rdata   (reg_rdata),
        .status_q    (status_q),
        .mask_q      (mask_q),
        .latch_mode  (latch_mode),
        .uv_code     (uv_code),
        .ov_code     (ov_code)
    );

    vfs_prot_fsm prot_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_cond    (uv_cond),
        .ov_cond    (ov_cond),
        .mask_q     (mask_q),
        .latch_mode (latch_mode),
        .pwm_off    (pwm_off),
        .restart_req(restart_req)
    );

    assign alert_n = ~|status_q;

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
    parameter int PG_DELAY_CYC = 62500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ss_active,
    input logic       clear_faults,
    input logic       wr_clr_ov,
    input logic       uv_cond,
    input logic       ov_cond,
    input logic [1:0] status_q,
    input logic [1:0] mask_q,
    input logic       pg,
    input logic       alert_n,
    input logic       pwm_off,
    input logic       restart_req
);
    localparam int CW = $clog2(PG_DELAY_CYC + 2);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (uv_cond || ov_cond || ss_active) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != {CW{1'b1}}) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R1: no undervoltage condition during soft-start
    a_r1_uv_quiet_in_ss: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |=> !uv_cond);

    // R2: overvoltage condition always reaches its flag
    a_r2_ov_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ov_cond |=> status_q[1]);

    // R4: pg rises only after the full quiet delay
    a_r4_pg_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg) |-> (int'(quiet_cnt) >= PG_DELAY_CYC));

    // R5: overvoltage flag is sticky without a clear
    a_r5_sticky_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[1] && !clear_faults && !wr_clr_ov) |=> status_q[1]);

    // R6: clear with no active condition empties the flags
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_faults && !uv_cond && !ov_cond) |=> (status_q == 2'b00));

    // R7: a set flag holds alert low in the next cycle
    a_r7_alert_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_cond || uv_cond) |=> !alert_n);

    // R9: unmasked overvoltage while running stops switching
    a_r9_ov_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_cond && !mask_q[1] && !pwm_off && !restart_req) |=> pwm_off);

    // R10: restart request is a single-cycle pulse following an off period
    a_r10_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);
    a_r10_restart_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> $past(pwm_off));

endmodule

bind vout_fault_supervisor vfs_checker #(.PG_DELAY_CYC(PG_DELAY_CYC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_active   (ss_active),
    .clear_faults(clear_faults),
    .wr_clr_ov   (reg_wr && (reg_addr == 2'd0) && reg_wdata[7]),
    .uv_cond     (uv_cond),
    .ov_cond     (ov_cond),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .pg          (pg),
    .alert_n     (alert_n),
    .pwm_off     (pwm_off),
    .restart_req (restart_req)
);

// File: tb/vout_fault_supervisor_tb_top.sv
module vout_fault_supervisor_tb_top;

    localparam int SW = 12;
    localparam int D  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] fb_sample = '0;
    logic [SW-1:0] ref_code = 12'd1000;
    logic          ss_active = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          clear_faults = 1'b0;
    logic          pg;
    logic          alert_n;
    logic          pwm_off;
    logic          restart_req;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    vout_fault_supervisor #(.SAMPLE_W(SW), .PG_DELAY_CYC(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_sample(fb_sample), .ref_code(ref_code),
        .ss_active(ss_active), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clear_faults(clear_faults),
        .pg(pg), .alert_n(alert_n), .pwm_off(pwm_off), .restart_req(restart_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_addr = a;
        reg_wdata = v;
        reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
        reg_addr = 2'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    function automatic logic uv_next(input logic cur, input int fb, input int rf, input int pct);
        if (cur) return !(fb * 100 > rf * (pct + 4));
        return fb * 100 < rf * pct;
    endfunction

    function automatic logic ov_next(input logic cur, input int fb, input int rf, input int pct);
        if (cur) return !(fb * 100 < rf * (pct - 4));
        return fb * 100 > rf * pct;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R4 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seed;
        int restarts;
        logic m_uv, m_ov;
        logic [1:0] sticky;
        seed = $urandom(32'h5EED1);

        // reset state
        fb_sample = 12'd1000;
        do_reset();
        chk("R12 pg reset", int'(pg), 0);
        chk("R7 alert reset", int'(alert_n), 1);
        chk("R9 pwm_off reset", int'(pwm_off), 0);
        rd(2'd0, v); chk("R12 status reset", int'(v), 'h00);
        rd(2'd1, v); chk("R8 mask reset", int'(v), 'h40);
        rd(2'd2, v); chk("R12 resp reset", int'(v), 'h00);
        rd(2'd3, v); chk("R12 limits reset", int'(v), 'h2D);

        // power-good delay
        step(D - 4);
        chk("R4 pg held during delay", int'(pg), 0);
        step(8);
        chk("R4 pg after delay", int'(pg), 1);

        // masked undervoltage
        fb_sample = 12'd790;
        step(1);
        chk("R4 pg falls at once", int'(pg), 0);
        step(2);
        rd(2'd0, v); chk("R1 uv flag", int'(v), 'h40);
        chk("R7 alert low", int'(alert_n), 0);
        chk("R8 masked uv keeps switching", int'(pwm_off), 0);

        // hysteresis band
        fb_sample = 12'd810;
        step(D + 6);
        chk("R3 uv band holds", int'(pg), 0);
        fb_sample = 12'd841;
        step(D + 6);
        chk("R3 uv release", int'(pg), 1);
        rd(2'd0, v); chk("R5 flag sticky", int'(v), 'h40);

        // write-one-to-clear
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R6 write zero no effect", int'(v), 'h40);
        wr(2'd0, 8'h40);
        rd(2'd0, v); chk("R6 w1c clears", int'(v), 'h00);
        chk("R7 alert released", int'(alert_n), 1);

        // unmasked overvoltage, hiccup
        fb_sample = 12'd1201;
        step(2);
        chk("R9 ov stops switching", int'(pwm_off), 1);
        step(1);
        rd(2'd0, v); chk("R2 ov flag", int'(v), 'h80);
        fb_sample = 12'd1170;
        step(5);
        chk("R3 ov band holds off", int'(pwm_off), 1);
        fb_sample = 12'd1150;
        restarts = 0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (restart_req) restarts++;
        end
        chk("R10 one restart pulse", restarts, 1);
        chk("R10 switching resumed", int'(pwm_off), 0);

        // clear strobe
        clear_faults = 1'b1;
        step(1);
        clear_faults = 1'b0;
        rd(2'd0, v); chk("R6 clear_faults", int'(v), 'h00);

        // alternate limits
        do_reset();
        wr(2'd3, 8'h07);
        rd(2'd3, v); chk("R12 limits readback", int'(v), 'h07);
        fb_sample = 12'd1105;
        step(3);
        rd(2'd0, v); chk("R2 ov at 110pct", int'(v), 'h80);
        fb_sample = 12'd835;
        step(3);
        rd(2'd0, v); chk("R1 uv at 84pct", int'(v), 'hC0);

        // soft-start
        do_reset();
        ss_active = 1'b1;
        fb_sample = 12'd500;
        step(3);
        rd(2'd0, v); chk("R1 uv ignored in soft-start", int'(v), 'h00);
        chk("R4 pg low in soft-start", int'(pg), 0);
        fb_sample = 12'd1300;
        step(3);
        rd(2'd0, v); chk("R2 ov in soft-start", int'(v), 'h80);
        chk("R9 ov off in soft-start", int'(pwm_off), 1);
        ss_active = 1'b0;

        // unmasked undervoltage
        fb_sample = 12'd1000;
        do_reset();
        wr(2'd1, 8'h00);
        fb_sample = 12'd700;
        step(3);
        chk("R8 unmasked uv stops", int'(pwm_off), 1);

        // latch-off
        fb_sample = 12'd1000;
        do_reset();
        wr(2'd2, 8'h01);
        fb_sample = 12'd1250;
        step(3);
        chk("R11 latch off", int'(pwm_off), 1);
        fb_sample = 12'd1000;
        restarts = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (restart_req) restarts++;
        end
        chk("R11 no restart", restarts, 0);
        chk("R11 stays off", int'(pwm_off), 1);
        do_reset();
        chk("R11 reset releases", int'(pwm_off), 0);

        // random samples with default limits
        m_uv = 1'b0;
        m_ov = 1'b0;
        sticky = 2'b00;
        for (int it = 0; it < 300; it++) begin
            int fbv;
            fbv = 650 + int'($urandom % 701);
            fb_sample = SW'(fbv);
            m_uv = uv_next(m_uv, fbv, 1000, 80);
            m_ov = ov_next(m_ov, fbv, 1000, 120);
            sticky = sticky | {m_ov, m_uv};
            step(3);
            rd(2'd0, v);
            chk("R5 random flags", int'(v), int'({sticky, 6'b0}));
            chk("R7 random alert", int'(alert_n), int'(sticky == 2'b00));
            chk("R9 random pwm_off", int'(pwm_off), int'(m_ov));
            if (it % 10 == 9) begin
                clear_faults = 1'b1;
                step(1);
                clear_faults = 1'b0;
                sticky = {m_ov, m_uv};
                step(1);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule